// File: doc/BRIEF.md
# Low-speed oscillator startup controller

This block supervises a 32.768 kHz clock source that is either a crystal or a digital clock applied from outside. Software programs a small control word: an enable, a crystal/external select, a three-bit startup length, separate enables for the 32 kHz output and the 1 kHz tick, and a ready-interrupt enable. Once enabled, the block counts a programmable number of raw oscillator cycles. It keeps the clock output masked for that whole time, then raises a ready flag and, if enabled, a single-cycle interrupt.

The raw oscillator is modelled as a level input. It is synchronised into the system clock domain, and its rising edges are counted. After ready, a divide-by-32 counter running on those edges produces a 1.024 kHz enable pulse. The block also drives the ownership controls for the two oscillator pins. There are two resets. The power-on reset clears everything. The ordinary system reset leaves the oscillator, its control word and its ready state untouched.

Top module: `lsosc_ctrl`

## Requirements
- R1: After power-on reset (por_n low), ctrl_rd reads 0, ready is 0, both pin overrides are 0, and clk32_out and tick1k stay 0.
- R2: Control word layout: bit 0 enable, bit 1 crystal select (1 = crystal, 0 = external clock), bits 4:2 startup code, bit 5 32 kHz output enable, bit 6 1 kHz tick enable, bit 7 ready-interrupt enable. While enabled in crystal mode, both pin_xin_ovr and pin_xout_ovr are 1. While enabled in external mode, only pin_xin_ovr is 1. While disabled, both are 0.
- R3: After enable, ready rises on the 2^(code+3)-th rising edge of osc_raw, and not on any earlier edge.
- R4: clk32_out is 0 throughout startup. Once ready, it follows the synchronised osc_raw level when crystal mode and the 32 kHz enable are both set.
- R5: irq is a one-cycle pulse on the 0-to-1 transition of ready, given only when the interrupt enable is set.
- R6: A system reset (rst_n low, por_n high) leaves ctrl_rd and ready unchanged. It clears werr and irq.
- R7: In external-clock mode, clk32_out and tick1k stay 0 even after ready.
- R8: A write that changes the enable bit and any other field at once is ignored, so ctrl_rd keeps its previous value. It sets werr, which stays set until a reset.
- R9: While ready, in crystal mode, with the 1 kHz enable set, tick1k pulses once for every 32 rising edges of osc_raw.
- R10: Clearing enable brings ready to 0 within two system clocks of the write. A later enable restarts the full startup count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low; oscillator state survives it |
| osc_raw | input | 1 | Raw oscillator level, asynchronous to clk |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word to write |
| ctrl_rd | output | 8 | Current control word |
| ready | output | 1 | Startup complete |
| irq | output | 1 | One-cycle ready interrupt |
| werr | output | 1 | Sticky flag for a rejected write |
| clk32_out | output | 1 | Gated 32.768 kHz clock level |
| tick1k | output | 1 | 1.024 kHz enable pulse, one clk wide |
| pin_xin_ovr | output | 1 | Controller owns the oscillator input pin |
| pin_xout_ovr | output | 1 | Controller owns the oscillator output pin |

## Verification
The hardest situation to reach is the exact edge on which startup completes. The count is of raw oscillator edges that pass a synchroniser, not of system clocks. The bench therefore drives osc_raw with slow, fully settled pulses and checks ready one edge short of the count and then again on the final edge. It does this for two different startup codes, the second after a disable, to show that the count restarts. A second hard case is a write that is rejected. No field can be changed together with the enable bit, so each enable is preceded by a configuration-only write. The rejected write is followed by reads of ctrl_rd and ready, which show that nothing moved.

// File: rtl/lsosc_pkg.sv
// Package: shared widths, the control word layout and the startup length function.
// Assumes the startup code is small enough that the count fits CNT_W bits.
package lsosc_pkg;
    localparam int STARTUP_W = 3;
    localparam int START_SHIFT = 3;
    localparam int CTRL_W = 5 + STARTUP_W;
    localparam int CNT_W = (1 << STARTUP_W) - 1 + START_SHIFT + 1;
    localparam int DIV_LOG2 = 5;

    typedef struct packed {
        logic                 ien;
        logic                 en1k;
        logic                 en32k;
        logic [STARTUP_W-1:0] startup;
        logic                 xtal;
        logic                 enable;
    } ctrl_t;

    // Number of raw oscillator edges to count for a startup code.
    function automatic logic [CNT_W-1:0] startup_len(input logic [STARTUP_W-1:0] code);
        return CNT_W'(1) << (int'(code) + START_SHIFT);
    endfunction
endpackage

// File: rtl/lsosc_regs.sv
// Control register with the write rule: a write that changes the enable bit
// together with any other field is dropped, and it sets a sticky error flag.
// The control word resets only on power-on. The error flag also clears on system reset.
module lsosc_regs
    import lsosc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rstn,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic              werr
);
    ctrl_t wr_word;
    logic  en_flip;
    logic  rest_diff;
    logic  bad_wr;

    // Classify the incoming write against the held word.
    always_comb begin
        wr_word   = ctrl_t'(wr_data);
        en_flip   = wr_word.enable != ctrl_q.enable;
        rest_diff = wr_word[CTRL_W-1:1] != ctrl_q[CTRL_W-1:1];
        bad_wr    = en_flip && rest_diff;
    end

    // Hold the control word; only power-on clears it.
    always_ff @(posedge clk) begin
        if (!por_n)
            ctrl_q <= '0;
        else if (wr_en && !bad_wr)
            ctrl_q <= wr_word;
    end

    // Sticky error flag for rejected writes.
    always_ff @(posedge clk) begin
        if (!sys_rstn)
            werr <= 1'b0;
        else if (wr_en && bad_wr)
            werr <= 1'b1;
    end

    assert_bad_write_ignored_R8: assert property (@(posedge clk) disable iff (!sys_rstn)
        (wr_en && bad_wr) |=> ($stable(ctrl_q) && werr));
endmodule

// File: rtl/lsosc_edge.sv
// Brings the raw oscillator level into the clk domain through two flops and
// flags each rising edge with a one-cycle tick. Assumes osc_raw is much slower than clk.
module lsosc_edge (
    input  logic clk,
    input  logic por_n,
    input  logic osc_raw,
    output logic osc_lvl,
    output logic osc_tick
);
    logic s1;
    logic s2;
    logic s3;

    // Synchroniser and the history flop used for edge detection.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= osc_raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Present the settled level and its rising edge.
    always_comb begin
        osc_lvl  = s2;
        osc_tick = s2 && !s3;
    end
endmodule

// File: rtl/lsosc_startup.sv
// Startup counter. While enabled and not yet ready it counts oscillator edges,
// and sets ready on the edge that completes 2^(code+3) of them. Disabling clears
// the counter and ready. The ready interrupt is a registered one-cycle pulse.
module lsosc_startup
    import lsosc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rstn,
    input  logic                 enable,
    input  logic                 ien,
    input  logic [STARTUP_W-1:0] code,
    input  logic                 osc_tick,
    output logic                 ready,
    output logic                 irq
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             done;

    // Detect the edge that ends the startup window.
    always_comb begin
        last = startup_len(code) - CNT_W'(1);
        done = enable && osc_tick && !ready && (cnt >= last);
    end

    // Count edges and hold ready; only power-on or disable clear them.
    always_ff @(posedge clk) begin
        if (!por_n || !enable) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (done) begin
            cnt   <= '0;
            ready <= 1'b1;
        end else if (osc_tick && !ready) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // One-cycle interrupt on the rising transition of ready.
    always_ff @(posedge clk) begin
        if (!sys_rstn)
            irq <= 1'b0;
        else
            irq <= done && ien;
    end

    assert_irq_on_rise_R5: assert property (@(posedge clk) disable iff (!sys_rstn)
        irq |-> (ready && !$past(ready)));
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!por_n)
        !enable |=> !ready);
    assert_ready_on_edge_R3: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ready) |-> $past(osc_tick));
endmodule

// File: rtl/lsosc_div.sv
// Divide-by-2^DIV_LOG2 counter on oscillator edges once ready. Issues a one-clk
// tick on each wrap when crystal mode and the tick enable are set.
module lsosc_div
    import lsosc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic xtal,
    input  logic en1k,
    input  logic osc_tick,
    output logic tick1k
);
    localparam logic [DIV_LOG2-1:0] DIV_TOP = '1;
    logic [DIV_LOG2-1:0] div;

    // Free-running divider, cleared when not running.
    always_ff @(posedge clk) begin
        if (!por_n || !run)
            div <= '0;
        else if (osc_tick)
            div <= div + 1'b1;
    end

    // Gate the wrap pulse to crystal mode with the tick enable.
    always_comb tick1k = run && xtal && en1k && osc_tick && (div == DIV_TOP);

    assert_tick1k_gated_R7: assert property (@(posedge clk) disable iff (!por_n)
        tick1k |-> (xtal && run));
endmodule

// File: rtl/lsosc_ctrl.sv
// Top of the low-speed oscillator startup controller. It joins the control
// register, the edge synchroniser, the startup counter and the 1 kHz divider.
// It also drives the output gating and the pin ownership. Assumes one system
// clock and two synchronous active-low resets.
module lsosc_ctrl
    import lsosc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              osc_raw,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              ready,
    output logic              irq,
    output logic              werr,
    output logic              clk32_out,
    output logic              tick1k,
    output logic              pin_xin_ovr,
    output logic              pin_xout_ovr
);
    ctrl_t ctrl_q;
    logic  sys_rstn;
    logic  osc_lvl;
    logic  osc_tick;

    // Either reset clears the flags that do not survive a system reset.
    always_comb sys_rstn = por_n && rst_n;

    lsosc_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rstn (sys_rstn),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .werr     (werr)
    );

    lsosc_edge u_edge (
        .clk      (clk),
        .por_n    (por_n),
        .osc_raw  (osc_raw),
        .osc_lvl  (osc_lvl),
        .osc_tick (osc_tick)
    );

    lsosc_startup u_start (
        .clk      (clk),
        .por_n    (por_n),
        .sys_rstn (sys_rstn),
        .enable   (ctrl_q.enable),
        .ien      (ctrl_q.ien),
        .code     (ctrl_q.startup),
        .osc_tick (osc_tick),
        .ready    (ready),
        .irq      (irq)
    );

    lsosc_div u_div (
        .clk      (clk),
        .por_n    (por_n),
        .run      (ready),
        .xtal     (ctrl_q.xtal),
        .en1k     (ctrl_q.en1k),
        .osc_tick (osc_tick),
        .tick1k   (tick1k)
    );

    // Output gating and pin ownership from the control word and ready.
    always_comb begin
        ctrl_rd      = ctrl_q;
        clk32_out    = osc_lvl && ready && ctrl_q.enable && ctrl_q.xtal && ctrl_q.en32k;
        pin_xin_ovr  = ctrl_q.enable;
        pin_xout_ovr = ctrl_q.enable && ctrl_q.xtal;
    end

    assert_pins_R2: assert property (@(posedge clk) disable iff (!por_n)
        pin_xout_ovr |-> pin_xin_ovr);
    assert_masked_R4: assert property (@(posedge clk) disable iff (!por_n)
        clk32_out |-> ready);
endmodule

// File: tb/lsosc_ctrl_test.sv
module lsosc_ctrl_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       osc_raw = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd;
    logic       ready, irq, werr, clk32_out, tick1k, pin_xin_ovr, pin_xout_ovr;

    int n_checks = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int tk_cnt = 0;
    int c32_cnt = 0;

    always #2 clk = ~clk;

    lsosc_ctrl uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .osc_raw(osc_raw),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd), .ready(ready),
        .irq(irq), .werr(werr), .clk32_out(clk32_out), .tick1k(tick1k),
        .pin_xin_ovr(pin_xin_ovr), .pin_xout_ovr(pin_xout_ovr)
    );

    // Output event counters, sampled on the falling edge.
    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (tick1k) tk_cnt++;
        if (clk32_out) c32_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d);
        @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 osc_raw = 1'b1;
            repeat (4) @(posedge clk);
            #1 osc_raw = 1'b0;
            repeat (4) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_por();
        @(posedge clk); #1 por_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_por();
        do_por();
        check("R1 ctrl_rd", ctrl_rd, 0);
        check("R1 ready", ready, 0);
        check("R1 pins", {pin_xin_ovr, pin_xout_ovr}, 0);
        c32_cnt = 0; tk_cnt = 0;
        pulses(3);
        check("R1 outputs off", c32_cnt + tk_cnt, 0);
    endtask

    task automatic t_xtal_startup();
        // crystal, code 0, 32k on, irq on: 8 edges
        write(8'b1010_0010);
        write(8'b1010_0011);
        check("R2 crystal pins", {pin_xin_ovr, pin_xout_ovr}, 3);
        irq_cnt = 0; c32_cnt = 0;
        pulses(7);
        check("R3 not ready at 7", ready, 0);
        check("R4 masked in startup", c32_cnt, 0);
        pulses(1);
        check("R3 ready at 8", ready, 1);
        check("R5 irq once", irq_cnt, 1);
        pulses(4);
        check("R4 clock passes", (c32_cnt > 0) ? 1 : 0, 1);
        check("R5 no repeat irq", irq_cnt, 1);
    endtask

    task automatic t_tick1k();
        write(8'b1110_0011);
        tk_cnt = 0;
        pulses(64);
        check("R9 two ticks per 64 edges", tk_cnt, 2);
    endtask

    task automatic t_sysreset_and_bad_write();
        irq_cnt = 0;
        write(8'b1110_0000);
        check("R8 ctrl unchanged", ctrl_rd, 8'hE3);
        check("R8 werr set", werr, 1);
        check("R8 ready kept", ready, 1);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R6 ctrl kept", ctrl_rd, 8'hE3);
        check("R6 ready kept", ready, 1);
        check("R6 werr cleared", werr, 0);
        check("R6 irq quiet", irq_cnt, 0);
    endtask

    task automatic t_disable_restart();
        @(posedge clk); #1 wr_en = 1'b1; wr_data = 8'hE2;
        @(posedge clk); #1 wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 ready cleared in two clocks", ready, 0);
        check("R2 pins released", {pin_xin_ovr, pin_xout_ovr}, 0);
        write(8'b1110_0110);
        write(8'b1110_0111);
        irq_cnt = 0;
        pulses(15);
        check("R10 full restart, not ready at 15", ready, 0);
        pulses(1);
        check("R3 code 1 ready at 16", ready, 1);
        check("R5 irq after restart", irq_cnt, 1);
    endtask

    task automatic t_external();
        write(8'b1110_0110);
        write(8'b0110_0000);
        write(8'b0110_0001);
        check("R2 external pins", {pin_xin_ovr, pin_xout_ovr}, 2);
        irq_cnt = 0; c32_cnt = 0; tk_cnt = 0;
        pulses(8);
        check("R3 external ready", ready, 1);
        check("R5 no irq when disabled", irq_cnt, 0);
        pulses(40);
        check("R7 clk32 forced off", c32_cnt, 0);
        check("R7 tick1k forced off", tk_cnt, 0);
        do_por();
        check("R1 ctrl cleared by por", ctrl_rd, 0);
        check("R1 ready cleared by por", ready, 0);
    endtask

    initial begin
        fork
            begin
                t_por();
                t_xtal_startup();
                t_tick1k();
                t_sysreset_and_bad_write();
                t_disable_restart();
                t_external();
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule